// File: doc/BRIEF.md
# Background Memory Signature Checker

This block checks the contents of a code memory while the chip runs. It reads the memory one word at a time and folds each word into a 32-bit multiple-input signature register. When the last word of the region has been folded in, it compares the register with an expected value that software has programmed. Reads go through a memory port that any engine access overrides. The checker therefore only uses memory bandwidth the engines leave idle.

Each finished pass sets a completion flag. A pass whose signature differs from the expected value also sets a mismatch flag and raises an exception request. The first mismatch turns the checker off. A clean pass starts the next one straight away.

Software sees two registers through simple write and read strobes:

- **Control/status word (select 0):**
  - bit 0 is the enable.
  - bit 1 is the completion flag.
  - bit 2 is the mismatch flag.
  - bits 12:8 hold the region size, counted in blocks of 2 KB minus one.
  - On a write, bit 3 = 1 clears the completion flag, and bit 4 = 1 acknowledges the exception.
- **Expected signature (select 1).**

Top module: `mem_sig_checker`

## Requirements
- R1: After reset, the enable, completion and mismatch flags read 0, `exc_req` is 0 and `mem_req` is 0.
- R2: While enabled with the engine idle, `mem_req` is high every cycle. `mem_addr` steps 0, 1, … up to (BLOCKS_M1+1)·WORDS_PER_BLOCK−1, then wraps to 0.
- R3: In any cycle where `eng_busy` is 1, `mem_req` is 0, and the address held on `mem_addr` does not change.
- R4: At the end of every pass, bit 1 of the control word is set. A matching pass leaves the enable at 1, and scanning goes on into a new pass.
- R5: The signature starts each pass at 0xFFFFFFFF. For each word w it becomes `{s[30:0],0} ^ (s[31] ? 0x04C11DB7 : 0) ^ w`. The final value is compared with the expected register.
- R6: On a mismatch, bit 2 and `exc_req` go to 1, the enable bit clears itself, and `mem_req` stays low after that.
- R7: Writing the control word with bit 3 = 1 clears the completion flag. Writing enable = 0 leaves the flag unchanged.
- R8: Writing the control word with bit 4 = 1 clears the mismatch flag and `exc_req`. It leaves the completion flag unchanged.
- R9: Clearing the enable returns `mem_addr` to 0. A later enable starts a fresh pass from the seed.
- R10: Bits 12:8 of the control word read BLOCKS_M1, and writes do not change them.
- R11: The expected-signature register (select 1) reads back the last value written to it.
- R12: Stalled cycles in the middle of a pass do not change the final signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control/status, 1 expected signature |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| eng_busy | input | 1 | Engine uses the memory port this cycle |
| mem_req | output | 1 | Checker read request |
| mem_addr | output | ADDR_W | Word address of the checker read |
| mem_rdata | input | 32 | Read data, valid one cycle after a request |
| exc_req | output | 1 | Exception request on signature mismatch |

## Verification
The hardest case to reach from the ports is the end of a pass while reads are being stalled: the last word's data must meet the seed reload without a word being lost or folded twice. The bench drives `eng_busy` from a small pseudo-random generator through a whole pass. It checks that the signature it computes itself still matches and that no mismatch follows. A second hard case is the self-clearing enable. To reach it, the bench programs an expected value that is off by one and then watches the enable, the exception and the request line.

// File: rtl/mem_sig_checker.sv
module mem_sig_checker #(
  parameter int WORDS_PER_BLOCK = 512,
  parameter int BLOCKS_M1       = 3,
  parameter int ADDR_W          = $clog2(WORDS_PER_BLOCK * 32)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              eng_busy,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [31:0]       mem_rdata,
  output logic              exc_req
);
  localparam logic [31:0]       POLY      = 32'h04C1_1DB7;
  localparam logic [31:0]       SEED      = 32'hFFFF_FFFF;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'((BLOCKS_M1 + 1) * WORDS_PER_BLOCK - 1);
  localparam logic [4:0]        SIZE_FLD  = 5'(BLOCKS_M1);

  logic              en_q, done_q, mis_q;
  logic [31:0]       exp_q, sig_q;
  logic [ADDR_W-1:0] addr_q;
  logic              pend_q, pend_last_q;

  wire        grant   = en_q && !eng_busy;
  wire        ctl_wr  = reg_we && !reg_sel;
  wire        exp_wr  = reg_we && reg_sel;
  wire [31:0] fold    = {sig_q[30:0], 1'b0} ^ (sig_q[31] ? POLY : 32'h0) ^ mem_rdata;
  wire        finish  = en_q && pend_q && pend_last_q;
  wire        mis_set = finish && (fold != exp_q);
  wire        at_last = (addr_q == LAST_ADDR);

  assign mem_req   = grant;
  assign mem_addr  = addr_q;
  assign exc_req   = mis_q;
  assign reg_rdata = reg_sel ? exp_q
                             : {19'd0, SIZE_FLD, 5'd0, mis_q, done_q, en_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      done_q <= 1'b0;
      mis_q  <= 1'b0;
      exp_q  <= 32'h0;
    end else begin
      if (mis_set && !mis_q)          en_q <= 1'b0;
      else if (ctl_wr)                en_q <= reg_wdata[0];
      if (finish)                     done_q <= 1'b1;
      else if (ctl_wr && reg_wdata[3]) done_q <= 1'b0;
      if (mis_set)                    mis_q <= 1'b1;
      else if (ctl_wr && reg_wdata[4]) mis_q <= 1'b0;
      if (exp_wr)                     exp_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q      <= '0;
      sig_q       <= SEED;
      pend_q      <= 1'b0;
      pend_last_q <= 1'b0;
    end else if (!en_q) begin
      addr_q      <= '0;
      sig_q       <= SEED;
      pend_q      <= 1'b0;
      pend_last_q <= 1'b0;
    end else begin
      pend_q      <= grant;
      pend_last_q <= grant && at_last;
      if (grant) addr_q <= at_last ? '0 : addr_q + 1'b1;
      if (pend_q) sig_q <= finish ? SEED : fold;
    end
  end
endmodule

module mem_sig_checker_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          mis,
  input logic          done,
  input logic          eng_busy,
  input logic          mem_req,
  input logic          exc_req,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] last_addr
);
  // R3
  busy_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> !mem_req);
  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> (!en || mem_addr == (($past(mem_addr) == last_addr) ? '0 : $past(mem_addr) + 1'b1)));
  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !mem_req) |=> (!en || $stable(mem_addr)));
  // R6
  mis_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mis) |-> !en);
  // R6
  exc_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exc_req) |-> done);
  // R9
  idle_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && $past(!en)) |-> mem_addr == '0);
endmodule

bind mem_sig_checker mem_sig_checker_chk #(.AW(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en_q), .mis(mis_q), .done(done_q),
  .eng_busy(eng_busy), .mem_req(mem_req), .exc_req(exc_req),
  .mem_addr(mem_addr), .last_addr(LAST_ADDR)
);

// File: tb/mem_sig_checker_tb.sv
module mem_sig_checker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WPB = 4;
  localparam int BM1 = 1;
  localparam int NW  = (BM1 + 1) * WPB;
  localparam int AW  = $clog2(WPB * 32);

  logic clk = 0, rst_n = 0, reg_we = 0, reg_sel = 0, eng_busy = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, mem_rdata = 0;
  logic mem_req, exc_req;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem [NW];
  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] good_sig;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_sig_checker #(.WORDS_PER_BLOCK(WPB), .BLOCKS_M1(BM1)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_busy(eng_busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .exc_req(exc_req));

  always @(posedge clk) if (mem_req) mem_rdata <= mem[mem_addr];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] calc_sig();
    logic [31:0] s = 32'hFFFF_FFFF;
    for (int i = 0; i < NW; i++)
      s = {s[30:0], 1'b0} ^ (s[31] ? 32'h04C1_1DB7 : 32'h0) ^ mem[i];
    return s;
  endfunction

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 0; reg_sel = 0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; #1;
    d = reg_rdata;
    reg_sel = 0;
  endtask

  task automatic wait_done(output logic ok);
    logic [31:0] v;
    ok = 0;
    for (int i = 0; i < 400; i++) begin
      rd(0, v);
      if (v[1]) begin ok = 1; break; end
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, v);
    chk("R1 flags", v[2:0], 0);
    chk("R1 exc_req", exc_req, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R10 size field", v[12:8], BM1);
    wr(0, 32'h0000_1F00);
    rd(0, v);
    chk("R10 size read-only", v[12:8], BM1);
  endtask

  task automatic t_expected_reg();
    logic [31:0] v;
    wr(1, 32'hA5C3_0F12);
    rd(1, v);
    chk("R11 expected readback", v, 32'hA5C3_0F12);
  endtask

  task automatic t_walk();
    wr(1, good_sig);
    wr(0, 32'h1);
    for (int i = 0; i < NW + 3; i++) begin
      @(negedge clk);
      chk("R2 mem_req", mem_req, 1);
      chk("R2 address order", 32'(mem_addr), 32'(i % NW));
    end
    wr(0, 32'h8);
  endtask

  task automatic t_busy();
    logic [AW-1:0] held;
    wr(0, 32'h1);
    @(negedge clk); @(negedge clk);
    eng_busy = 1;
    @(negedge clk);
    held = mem_addr;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R3 no request while busy", mem_req, 0);
      chk("R3 address held", 32'(mem_addr), 32'(held));
    end
    eng_busy = 0;
    wr(0, 32'h8);
  endtask

  task automatic t_match_pass();
    logic ok; logic [31:0] v;
    wr(1, good_sig);
    wr(0, 32'h9);
    wait_done(ok);
    chk("R4 pass completes", ok, 1);
    rd(0, v);
    chk("R5 matching signature no mismatch", v[2], 0);
    chk("R4 enable stays", v[0], 1);
    chk("R5 no exception", exc_req, 0);
    wr(0, 32'h9);
    rd(0, v);
    chk("R7 done cleared", v[1], 0);
    wait_done(ok);
    chk("R4 next pass completes", ok, 1);
    wr(0, 32'h0);
    rd(0, v);
    chk("R7 disable keeps done", v[1], 1);
    @(negedge clk); @(negedge clk);
    chk("R9 address back to 0", 32'(mem_addr), 0);
    wr(0, 32'h8);
  endtask

  task automatic t_mismatch();
    logic ok; logic [31:0] v;
    wr(1, good_sig ^ 32'h1);
    wr(0, 32'h1);
    wait_done(ok);
    chk("R6 pass completes", ok, 1);
    rd(0, v);
    chk("R6 mismatch flag", v[2], 1);
    chk("R6 enable self-cleared", v[0], 0);
    chk("R6 exc_req", exc_req, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R6 scanning stopped", mem_req, 0);
    end
    wr(0, 32'h10);
    rd(0, v);
    chk("R8 mismatch cleared", v[2], 0);
    chk("R8 exc_req cleared", exc_req, 0);
    chk("R8 done untouched", v[1], 1);
    wr(0, 32'h8);
  endtask

  task automatic t_stall_pass();
    logic ok; logic [31:0] v;
    logic [7:0] lf = 8'h5A;
    wr(1, good_sig);
    wr(0, 32'h1);
    ok = 0;
    for (int i = 0; i < 400 && !ok; i++) begin
      @(negedge clk);
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      eng_busy = lf[0];
      reg_sel = 0; #1;
      ok = reg_rdata[1];
    end
    eng_busy = 0;
    chk("R12 stalled pass completes", ok, 1);
    rd(0, v);
    chk("R12 stalled pass matches", v[2], 0);
    wr(0, 32'h8);
  endtask

  task automatic t_restart();
    logic ok; logic [31:0] v;
    wr(1, good_sig);
    wr(0, 32'h1);
    repeat (3) @(negedge clk);
    wr(0, 32'h0);
    wr(0, 32'h1);
    wait_done(ok);
    chk("R9 restart completes", ok, 1);
    rd(0, v);
    chk("R9 restart from seed matches", v[2], 0);
    wr(0, 32'h8);
  endtask

  initial begin
    for (int i = 0; i < NW; i++) mem[i] = (32'(i) * 32'h9E37_79B9) ^ 32'h1234_0F0F;
    good_sig = calc_sig();
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_expected_reg();
    t_walk();
    t_busy();
    t_match_pass();
    t_mismatch();
    t_stall_pass();
    t_restart();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule